// File: doc/BRIEF.md
# Conditional Input Stream Router

The router feeds a row of SIMD lanes from a row of banked stream buffers when only some lanes should do work. Every bank offers one element per transfer; a full row of bank elements is copied into a shared circular staging buffer, in stream order with bank 0 first. Each lane presents a predicate bit. Every lane whose predicate is set is offered the next unconsumed element of the stream. Elements are handed out in ascending lane order, starting from the oldest staged element. A lane whose predicate is clear is offered nothing.

Elements that no predicated lane takes stay staged for later cycles. This lets software shrink the active lane count at run time, for example by setting the predicate only on the lowest lanes. All of the stream then flows through those lanes and the rest can be idled. The lane index of each element comes from a prefix count of the predicate bits, and a crossbar reads the element at that offset from the read pointer.

A small state machine tracks the staging occupancy. ST_IDLE means nothing is staged. ST_STAGED means elements are waiting and a further row still fits. ST_STALL means fewer free slots remain than a row needs. The machine moves to the state that matches the occupancy after each clock: rows arriving move it ST_IDLE to ST_STAGED, filling moves it ST_STAGED to ST_STALL, draining moves it ST_STALL to ST_STAGED, and emptying moves it ST_STAGED to ST_IDLE. Bank rows are accepted in ST_IDLE and ST_STAGED, and lane offers are made in ST_STAGED and ST_STALL.

Top module: `cond_stream_router`

## Requirements
- R1: After reset no lane valid is asserted and the staging buffer is empty, so bank rows are accepted as soon as every bank is valid.
- R2: A row is transferred only as a whole. Every bank_ready bit is high exactly when all bank_valid bits are high and at least LANES slots are free. Within a row, bank i becomes stream element (row base + i).
- R3: The staging buffer holds LANES*DEPTH_FACTOR elements. When fewer than LANES slots are free, bank_ready is low on every bank.
- R4: A lane whose predicate is 0 never has lane_valid asserted, and it consumes nothing.
- R5: The predicated lanes, in ascending lane order, are offered consecutive stream elements starting at the oldest unconsumed staged element. Lane i gets offset k, where k is the number of predicated lanes below i.
- R6: lane_valid of lane i is high only when its predicate is 1 and its offset k is less than the number of staged elements.
- R7: The offered elements are consumed only in a cycle where every lane with lane_valid high also has lane_ready high. Otherwise nothing is consumed, and the same elements are offered again.
- R8: A row accepted at a clock edge can be offered from the next cycle onward. Unconsumed elements carry over in order to later cycles.
- R9: With the predicate set only on the lowest M lanes, the entire stream passes through those M lanes in order, M elements per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_valid | input | LANES | Per-bank element valid |
| bank_data | input | LANES*WIDTH | Per-bank element, bank i at bits [i*WIDTH +: WIDTH] |
| bank_ready | output | LANES | Per-bank accept (row transfer) |
| lane_pred | input | LANES | Per-lane predicate, 1 = wants the next element |
| lane_ready | input | LANES | Per-lane accept |
| lane_valid | output | LANES | Per-lane element offered |
| lane_data | output | LANES*WIDTH | Per-lane element, lane i at bits [i*WIDTH +: WIDTH] |

## Verification
The bench builds the router with LANES=4, WIDTH=16 and DEPTH_FACTOR=2, which gives an 8-slot staging buffer. With this setting two accepted rows reach the stall threshold. The pointers wrap after a few rows, so wrap-around of the crossbar read index is exercised by every longer scenario. The four lanes are also enough to cover full, single-lane, sparse and empty predicate patterns, as well as offers cut short by a low staged count.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STAGED = 2'd1,
        ST_STALL  = 2'd2
    } route_state_t;

    // Circular index: base and offset are both below depth.
    function automatic int wrap_idx(input int base, input int offset, input int depth);
        int sum;
        sum = base + offset;
        if (sum >= depth) begin
            sum = sum - depth;
        end
        return sum;
    endfunction

endpackage

// File: rtl/crs_fsm.sv
module crs_fsm
    import crs_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 16,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] cnt_next,
    output route_state_t    state,
    output logic            accept_rows,
    output logic            offer_en
);

    localparam int ROW_LIMIT = DEPTH - LANES;

    route_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cnt_next != '0) begin
                    state_nx = (cnt_next > CNTW'(ROW_LIMIT)) ? ST_STALL : ST_STAGED;
                end
            end
            ST_STAGED: begin
                if (cnt_next == '0) begin
                    state_nx = ST_IDLE;
                end else if (cnt_next > CNTW'(ROW_LIMIT)) begin
                    state_nx = ST_STALL;
                end
            end
            ST_STALL: begin
                if (cnt_next == '0) begin
                    state_nx = ST_IDLE;
                end else if (cnt_next <= CNTW'(ROW_LIMIT)) begin
                    state_nx = ST_STAGED;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        accept_rows = 1'b0;
        offer_en    = 1'b0;
        unique case (state)
            ST_IDLE:   accept_rows = 1'b1;
            ST_STAGED: begin
                accept_rows = 1'b1;
                offer_en    = 1'b1;
            end
            ST_STALL:  offer_en = 1'b1;
            default: begin
                accept_rows = 1'b0;
                offer_en    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/crs_stage.sv
module crs_stage
    import crs_pkg::*;
#(
    parameter int LANES = 8,
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [LANES*WIDTH-1:0] row_data,
    input  logic [CNTW-1:0]        pop_n,
    output logic [PTRW-1:0]        rd_ptr,
    output logic [CNTW-1:0]        count,
    output logic [CNTW-1:0]        cnt_next,
    output logic [DEPTH*WIDTH-1:0] slots_flat
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTRW-1:0]  wr_ptr;

    always_comb begin
        cnt_next = count - pop_n;
        if (push) begin
            cnt_next = cnt_next + CNTW'(LANES);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            for (int i = 0; i < LANES; i++) begin
                mem[wrap_idx(int'(wr_ptr), i, DEPTH)] <= row_data[i*WIDTH +: WIDTH];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= PTRW'(wrap_idx(int'(wr_ptr), LANES, DEPTH));
            end
            rd_ptr <= PTRW'(wrap_idx(int'(rd_ptr), int'(pop_n), DEPTH));
            count  <= cnt_next;
        end
    end

    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            slots_flat[s*WIDTH +: WIDTH] = mem[s];
        end
    end

    // R3: a row is only written when it fits.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count <= CNTW'(DEPTH - LANES)));

    // R6: never hand out more elements than are staged.
    p_pop_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n <= count);

endmodule

// File: rtl/crs_xbar.sv
module crs_xbar
    import crs_pkg::*;
#(
    parameter int LANES = 8,
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic [LANES-1:0]       lane_pred,
    input  logic                   offer_en,
    input  logic [CNTW-1:0]        count,
    input  logic [PTRW-1:0]        rd_ptr,
    input  logic [DEPTH*WIDTH-1:0] slots_flat,
    output logic [LANES-1:0]       lane_valid,
    output logic [LANES*WIDTH-1:0] lane_data,
    output logic [CNTW-1:0]        n_offer
);

    logic [CNTW-1:0] rank;

    // Prefix count of predicates gives each lane its offset from the read pointer.
    always_comb begin
        rank    = '0;
        n_offer = '0;
        for (int i = 0; i < LANES; i++) begin
            lane_valid[i] = offer_en && lane_pred[i] && (rank < count);
            lane_data[i*WIDTH +: WIDTH] =
                slots_flat[wrap_idx(int'(rd_ptr), int'(rank), DEPTH)*WIDTH +: WIDTH];
            if (lane_valid[i]) begin
                n_offer = n_offer + CNTW'(1);
            end
            if (lane_pred[i]) begin
                rank = rank + CNTW'(1);
            end
        end
    end

endmodule

// File: rtl/cond_stream_router.sv
module cond_stream_router
    import crs_pkg::*;
#(
    parameter int LANES        = 8,
    parameter int WIDTH        = 16,
    parameter int DEPTH_FACTOR = 2,
    localparam int DEPTH = LANES * DEPTH_FACTOR,
    localparam int PTRW  = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       bank_valid,
    input  logic [LANES*WIDTH-1:0] bank_data,
    output logic [LANES-1:0]       bank_ready,
    input  logic [LANES-1:0]       lane_pred,
    input  logic [LANES-1:0]       lane_ready,
    output logic [LANES-1:0]       lane_valid,
    output logic [LANES*WIDTH-1:0] lane_data
);

    route_state_t           fsm_state;
    logic                   accept_rows;
    logic                   offer_en;
    logic                   row_fire;
    logic                   deliver;
    logic [CNTW-1:0]        pop_n;
    logic [CNTW-1:0]        n_offer;
    logic [CNTW-1:0]        stg_count;
    logic [CNTW-1:0]        cnt_next;
    logic [PTRW-1:0]        rd_ptr;
    logic [DEPTH*WIDTH-1:0] slots_flat;

    assign row_fire   = accept_rows && (&bank_valid);
    assign bank_ready = {LANES{row_fire}};
    assign deliver    = &(~lane_valid | lane_ready);
    assign pop_n      = deliver ? n_offer : '0;

    crs_fsm #(.LANES(LANES), .DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_next   (cnt_next),
        .state      (fsm_state),
        .accept_rows(accept_rows),
        .offer_en   (offer_en)
    );

    crs_stage #(.LANES(LANES), .WIDTH(WIDTH), .DEPTH(DEPTH)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (row_fire),
        .row_data  (bank_data),
        .pop_n     (pop_n),
        .rd_ptr    (rd_ptr),
        .count     (stg_count),
        .cnt_next  (cnt_next),
        .slots_flat(slots_flat)
    );

    crs_xbar #(.LANES(LANES), .WIDTH(WIDTH), .DEPTH(DEPTH)) u_xbar (
        .lane_pred (lane_pred),
        .offer_en  (offer_en),
        .count     (stg_count),
        .rd_ptr    (rd_ptr),
        .slots_flat(slots_flat),
        .lane_valid(lane_valid),
        .lane_data (lane_data),
        .n_offer   (n_offer)
    );

    // R1: the idle state and the staging occupancy agree.
    p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> (stg_count == '0));

    // R7: a blocked offer consumes nothing.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lane_valid) && !deliver) |=> (stg_count >= $past(stg_count)));

    // R5: offers fill predicated lanes from the lowest lane upward.
    for (genvar g = 1; g < LANES; g++) begin : g_prefix
        p_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_valid[g] && lane_pred[g-1]) |-> lane_valid[g-1]);
    end

endmodule

// File: tb/cond_stream_router_test.sv
module cond_stream_router_test;

    localparam int N  = 4;
    localparam int W  = 16;
    localparam int DF = 2;
    localparam int D  = N * DF;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     bank_valid = '0;
    logic [N*W-1:0]   bank_data = '0;
    logic [N-1:0]     bank_ready;
    logic [N-1:0]     lane_pred = '0;
    logic [N-1:0]     lane_ready = '0;
    logic [N-1:0]     lane_valid;
    logic [N*W-1:0]   lane_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    int m_cnt = 0;
    int m_head = 0;
    int m_next = 0;

    always #2.5 clk = ~clk;

    cond_stream_router #(.LANES(N), .WIDTH(W), .DEPTH_FACTOR(DF)) uut (
        .clk(clk), .rst_n(rst_n),
        .bank_valid(bank_valid), .bank_data(bank_data), .bank_ready(bank_ready),
        .lane_pred(lane_pred), .lane_ready(lane_ready),
        .lane_valid(lane_valid), .lane_data(lane_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check outputs against the model, advance the model.
    task automatic step(input logic [N-1:0] pred, input logic [N-1:0] lrdy,
                        input logic [N-1:0] bval, input string req);
        logic [N-1:0] e_valid;
        logic [N-1:0] e_ready;
        bit           data_ok;
        bit           del;
        int           rank;
        int           pop;
        int           bad_act;
        int           bad_exp;
        @(negedge clk);
        lane_pred  = pred;
        lane_ready = lrdy;
        bank_valid = bval;
        for (int i = 0; i < N; i++) begin
            bank_data[i*W +: W] = W'(m_next + i);
        end
        #1;
        e_ready = ((m_cnt <= D - N) && (&bval)) ? '1 : '0;
        rank = 0;
        data_ok = 1'b1;
        bad_act = 0;
        bad_exp = 0;
        for (int i = 0; i < N; i++) begin
            e_valid[i] = pred[i] && (rank < m_cnt);
            if (e_valid[i] && lane_valid[i] && (lane_data[i*W +: W] != W'(m_head + rank))) begin
                data_ok = 1'b0;
                bad_act = int'(lane_data[i*W +: W]);
                bad_exp = m_head + rank;
            end
            if (pred[i]) rank++;
        end
        check(bank_ready == e_ready, req, "bank_ready", int'(bank_ready), int'(e_ready));
        check(lane_valid == e_valid, req, "lane_valid", int'(lane_valid), int'(e_valid));
        check(data_ok, req, "lane_data", bad_act, bad_exp);
        del = &(~e_valid | lrdy);
        pop = del ? $countones(e_valid) : 0;
        @(posedge clk);
        m_cnt  = m_cnt - pop + ((e_ready != '0) ? N : 0);
        m_head = m_head + pop;
        if (e_ready != '0) m_next = m_next + N;
    endtask

    task automatic t_reset();
        // R1: empty after reset, rows accepted at once, nothing offered.
        step('1, '1, '0, "R1");
        step('1, '1, '1, "R1");
    endtask

    task automatic t_full_flow();
        // R2 R5 R8: all lanes predicated, steady stream, one-cycle latency.
        for (int c = 0; c < 6; c++) step('1, '1, '1, "R5");
        step('1, '1, '0, "R8");
        step('1, '1, '0, "R8");
    endtask

    task automatic t_shrink();
        // R9: only lane 0 predicated; stream drains through it, stalls appear (R3).
        for (int c = 0; c < 12; c++) step(4'b0001, '1, '1, "R9");
        for (int c = 0; c < 10; c++) step(4'b0001, '1, '0, "R9");
        // R9 with two lowest lanes
        for (int c = 0; c < 6; c++) step(4'b0011, '1, '1, "R9");
    endtask

    task automatic t_sparse();
        // R4 R5: lanes 1 and 2 only; lanes 0 and 3 stay silent.
        for (int c = 0; c < 6; c++) step(4'b0110, '1, (c % 2 == 0) ? '1 : '0, "R4");
        step(4'b1010, '1, '0, "R5");
    endtask

    task automatic t_zero_pred();
        // R4: no predicates, nothing consumed; the same head is offered after.
        step('0, '1, '0, "R4");
        step('0, '1, '0, "R4");
        step('1, '1, '0, "R4");
    endtask

    task automatic t_backpressure();
        // R7: lane 2 not ready blocks the whole delivery.
        step('1, '1, '1, "R7");
        step('1, 4'b1011, '0, "R7");
        step('1, 4'b1011, '0, "R7");
        step('1, '1, '0, "R7");
        // R7: an unready lane with predicate 0 does not block.
        step(4'b0011, 4'b0011, '0, "R7");
    endtask

    task automatic t_partial();
        // R6: drain, stage one row, take two, then only two remain for four lanes.
        for (int c = 0; c < 8; c++) step('1, '1, '0, "R6");
        step('0, '1, '1, "R6");
        step(4'b0011, '1, '0, "R6");
        step('1, 4'b0011, '0, "R6");
        step('1, '1, '0, "R6");
    endtask

    task automatic t_stall();
        // R3: no consumption; third row does not fit in 8 slots.
        step('0, '1, '1, "R3");
        step('0, '1, '1, "R3");
        step('0, '1, '1, "R3");
        step('0, '1, '1, "R3");
        // R2: one bank not valid holds the whole row.
        for (int c = 0; c < 4; c++) step('1, '1, '0, "R2");
        step('1, '1, 4'b1101, "R2");
        step('1, '1, '1, "R2");
        step('1, '1, '0, "R8");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_flow();
        t_shrink();
        t_sparse();
        t_zero_pred();
        t_backpressure();
        t_partial();
        t_stall();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule